// File: doc/BRIEF.md
# Daisy-Chain Frame Forwarder

This block is one repeater stage on a point-to-point memory channel in which buffer modules are chained one after another. Frames heading toward the memory arrive as 10 parallel lanes, one transfer per clock, with a strobe on the first transfer. Each frame is 12 transfers (120 bits) long. The stage collects a whole frame and checks its 12-bit CRC. It then sends the frame on, bit for bit, to the next stage in the chain. Every frame is forwarded, whether it is addressed here or not and whether or not its CRC is good.

While a frame is being retransmitted, the stage looks at its three command slots one after another. It hands on to a local DRAM-command port only the commands whose target ID equals the stage's own module ID, keeping the slot order. It makes no scheduling decisions. A frame with a CRC mismatch yields no local commands and raises a one-cycle error flag.

The frame layout is as follows. Bits 5:0 are a header that is carried along untouched. Slot k occupies bits [6+34k +: 34]. Within a slot, bit 0 is the valid bit, bits 3:1 hold the target module ID, bits 6:4 hold the opcode, and bits 33:7 hold a 27-bit address. Bits 119:108 carry the CRC. Transfer k of a frame carries frame bits [10k +: 10].

Top module: `chain_frame_fwd`

## Requirements
- R1: While reset is asserted and in the cycles after its release until the first frame completes, out_sof, out_lanes, cmd_valid, cmd_op, cmd_addr and crc_err are all zero.
- R2: A frame whose first transfer is presented with in_sof in cycle s is retransmitted unchanged. out_sof is high in cycle s+12, and out_lanes in cycle s+12+k equals input transfer k, for k from 0 to 11.
- R3: Every complete frame is forwarded, including frames with no slot for this module and frames that fail the CRC check.
- R4: The check value is a 12-bit CRC over frame bits 0 to 107, fed LSB first into a shift register that is cleared at the start of each frame and shifts toward its MSB. When the feedback bit (register MSB XOR data bit) is set, the generator polynomial (default 12'h80F) is XORed in. The received CRC is bits 119:108. On a mismatch, crc_err is high for exactly the single cycle s+12.
- R5: In a frame that passes the CRC check, slot k produces cmd_valid in cycle s+12+k when all of the following hold: the slot's valid bit is 1, its ID equals MODULE_ID, and its opcode is activate (1), read (2), write (3) or refresh (4). In that cycle cmd_op and cmd_addr carry the slot's opcode and address.
- R6: A slot with its valid bit at 0, a different target ID, the no-op code 0, or a reserved code 5 to 7 produces no command. cmd_op and cmd_addr read zero whenever cmd_valid is low.
- R7: A frame that fails the CRC check produces no command from any of its slots.
- R8: An in_sof that arrives before a frame is complete discards the partial frame and starts a new one. The partial frame is never forwarded.
- R9: Lane data presented while no frame is in progress and without in_sof is ignored. When nothing is being forwarded, out_lanes is zero.
- R10: Frames may arrive back to back, each in_sof exactly 12 cycles after the previous one, and each is forwarded and decoded without loss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_sof | input | 1 | Marks the first transfer of an incoming frame |
| in_lanes | input | 10 | Incoming lane data, one transfer per cycle |
| out_sof | output | 1 | Marks the first transfer of a forwarded frame |
| out_lanes | output | 10 | Forwarded lane data |
| cmd_valid | output | 1 | A local command is presented |
| cmd_op | output | 3 | Opcode of the local command |
| cmd_addr | output | 27 | Address bits of the local command |
| crc_err | output | 1 | One-cycle pulse for a frame with a bad CRC |

## Verification
The assertions assume that whoever drives the link starts every frame with in_sof and that no frame completes less than 12 cycles after the previous one. This holds because of the framing itself, since completing a frame takes 12 transfers. The bench builds its stimulus from whole frames placed on a cycle grid: back to back, with gaps, or cut short by an early in_sof. Stray lane data is only driven while no frame is in progress. This keeps the input within those assumptions while still reaching restart and idle-noise cases.

// File: rtl/chain_frame_fwd.sv
module chain_frame_fwd #(
  parameter int LANES = 10,
  parameter int BEATS = 12,
  parameter int CRC_W = 12,
  parameter logic [CRC_W-1:0] CRC_POLY = 12'h80F,
  parameter int ID_W = 3,
  parameter int OP_W = 3,
  parameter int SLOTS = 3,
  parameter int HDR_W = 6,
  parameter logic [ID_W-1:0] MODULE_ID = '0,
  parameter int ADDR_W = (LANES*BEATS - CRC_W - HDR_W) / SLOTS - 1 - ID_W - OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_sof,
  input  logic [LANES-1:0]  in_lanes,
  output logic              out_sof,
  output logic [LANES-1:0]  out_lanes,
  output logic              cmd_valid,
  output logic [OP_W-1:0]   cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              crc_err
);
  localparam int FRAME_W = LANES * BEATS;
  localparam int BODY_W  = FRAME_W - CRC_W;
  localparam int SLOT_W  = 1 + ID_W + OP_W + ADDR_W;
  localparam int CNT_W   = $clog2(BEATS);
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);
  localparam logic [CNT_W-1:0] NSLOT     = CNT_W'(SLOTS);
  localparam logic [OP_W-1:0]  OP_FIRST  = OP_W'(1);
  localparam logic [OP_W-1:0]  OP_LAST   = OP_W'(4);

  function automatic int body_bits(input int b);
    if (b * LANES >= BODY_W) return 0;
    if (BODY_W - b * LANES > LANES) return LANES;
    return BODY_W - b * LANES;
  endfunction

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [LANES-1:0] d,
                                                input int n);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < LANES; i++) begin
      if (i < n) begin
        fb = r[CRC_W-1] ^ d[i];
        r = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
      end
    end
    return r;
  endfunction

  logic                     in_busy;
  logic [CNT_W-1:0]         in_cnt;
  logic [FRAME_W-LANES-1:0] asm_buf;
  logic [CRC_W-1:0]         crc_q, crc_base, crc_next;
  logic [FRAME_W-1:0]       hold_buf;
  logic                     out_active;
  logic [CNT_W-1:0]         out_cnt;
  logic                     frame_ok;
  logic                     crc_err_q;
  logic [SLOT_W-1:0]        cur_slot;

  wire               take    = in_sof | in_busy;
  wire [CNT_W-1:0]   beat    = in_sof ? '0 : in_cnt;
  wire               last    = take && (beat == LAST_BEAT);
  wire [FRAME_W-1:0] full    = {in_lanes, asm_buf};
  wire               crc_hit = (crc_next == full[FRAME_W-1 -: CRC_W]);

  always_comb begin
    crc_base = in_sof ? '0 : crc_q;
    crc_next = crc_base;
    for (int b = 0; b < BEATS; b++)
      if (beat == CNT_W'(b)) crc_next = crc_step(crc_base, in_lanes, body_bits(b));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_busy <= 1'b0;
      in_cnt  <= '0;
      asm_buf <= '0;
      crc_q   <= '0;
    end else if (take) begin
      for (int b = 0; b < BEATS - 1; b++)
        if (beat == CNT_W'(b)) asm_buf[b*LANES +: LANES] <= in_lanes;
      crc_q   <= crc_next;
      in_busy <= !last;
      in_cnt  <= last ? '0 : beat + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_buf   <= '0;
      out_active <= 1'b0;
      out_cnt    <= '0;
      frame_ok   <= 1'b0;
      crc_err_q  <= 1'b0;
    end else if (last) begin
      hold_buf   <= full;
      out_active <= 1'b1;
      out_cnt    <= '0;
      frame_ok   <= crc_hit;
      crc_err_q  <= !crc_hit;
    end else begin
      crc_err_q <= 1'b0;
      if (out_active) begin
        out_cnt <= out_cnt + 1'b1;
        if (out_cnt == LAST_BEAT) out_active <= 1'b0;
      end
    end
  end

  always_comb begin
    out_lanes = '0;
    cur_slot  = '0;
    for (int b = 0; b < BEATS; b++)
      if (out_active && out_cnt == CNT_W'(b)) out_lanes = hold_buf[b*LANES +: LANES];
    for (int s = 0; s < SLOTS; s++)
      if (out_cnt == CNT_W'(s)) cur_slot = hold_buf[HDR_W + s*SLOT_W +: SLOT_W];
  end

  wire [ID_W-1:0]   slot_id = cur_slot[ID_W:1];
  wire [OP_W-1:0]   slot_op = cur_slot[ID_W+OP_W:ID_W+1];
  wire              op_ok   = (slot_op >= OP_FIRST) && (slot_op <= OP_LAST);

  assign out_sof   = out_active && (out_cnt == '0);
  assign cmd_valid = out_active && frame_ok && (out_cnt < NSLOT) && cur_slot[0]
                     && (slot_id == MODULE_ID) && op_ok;
  assign cmd_op    = cmd_valid ? slot_op : '0;
  assign cmd_addr  = cmd_valid ? cur_slot[SLOT_W-1 -: ADDR_W] : '0;
  assign crc_err   = crc_err_q;

  AST_SOF_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> $past(in_sof, BEATS)); // R2
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |=> !crc_err); // R4
  AST_ERR_WITH_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> out_sof); // R4
  AST_NO_CMD_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> !cmd_valid); // R7
  AST_CMD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (out_sof || $past(out_sof) || $past(out_sof, 2))); // R5
  AST_CMD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_op != '0 && cmd_op <= OP_LAST)); // R6
  AST_QUIET_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> (cmd_op == '0 && cmd_addr == '0)); // R6
endmodule

// File: tb/sim_chain_frame_fwd.sv
module sim_chain_frame_fwd;
  localparam int NCYC = 140;
  localparam logic [2:0] MY_ID = 3'd5;
  localparam logic [11:0] POLY = 12'h80F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_sof = 1'b0;
  logic [9:0] in_lanes = '0;
  logic out_sof, cmd_valid, crc_err;
  logic [9:0] out_lanes;
  logic [2:0] cmd_op;
  logic [26:0] cmd_addr;

  always #4 clk = ~clk;

  chain_frame_fwd #(.MODULE_ID(MY_ID)) u0 (
    .clk(clk), .rst_n(rst_n), .in_sof(in_sof), .in_lanes(in_lanes),
    .out_sof(out_sof), .out_lanes(out_lanes), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .crc_err(crc_err));

  int total = 0, bad = 0;
  bit done = 0;

  logic        st_sof   [NCYC];
  logic [9:0]  st_lanes [NCYC];
  logic        e_sof    [NCYC];
  logic [9:0]  e_lanes  [NCYC];
  logic        e_cv     [NCYC];
  logic [2:0]  e_op     [NCYC];
  logic [26:0] e_addr   [NCYC];
  logic        e_err    [NCYC];
  string       ltag     [NCYC];
  string       ctag     [NCYC];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input int cyc);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [11:0] crc_of(input logic [119:0] f);
    logic [11:0] c = '0;
    for (int i = 0; i < 108; i++) begin
      logic fb = c[11] ^ f[i];
      c = {c[10:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  function automatic logic [33:0] slot(input bit v, input logic [2:0] id, input logic [2:0] op, input logic [26:0] a);
    return {a, op, id, v};
  endfunction

  function automatic logic [119:0] frame(input logic [5:0] hdr, input logic [33:0] s0, s1, s2, input bit corrupt);
    logic [119:0] f;
    f[5:0] = hdr;
    f[39:6] = s0;
    f[73:40] = s1;
    f[107:74] = s2;
    f[119:108] = crc_of(f) ^ {11'd0, corrupt};
    return f;
  endfunction

  task automatic sched(input int s, input logic [119:0] f, input string tag);
    bit good = (f[119:108] == crc_of(f));
    for (int k = 0; k < 12; k++) begin
      st_sof[s+k] = (k == 0);
      st_lanes[s+k] = f[k*10 +: 10];
      e_lanes[s+12+k] = f[k*10 +: 10];
      ltag[s+12+k] = tag;
    end
    e_sof[s+12] = 1'b1;
    e_err[s+12] = !good;
    for (int k = 0; k < 3; k++) begin
      logic [33:0] sl = f[6+34*k +: 34];
      ctag[s+12+k] = good ? "R6" : "R7";
      if (good && sl[0] && sl[3:1] == MY_ID && sl[6:4] >= 3'd1 && sl[6:4] <= 3'd4) begin
        e_cv[s+12+k] = 1'b1;
        e_op[s+12+k] = sl[6:4];
        e_addr[s+12+k] = sl[33:7];
        ctag[s+12+k] = "R5";
      end
    end
  endtask

  initial begin
    for (int c = 0; c < NCYC; c++) begin
      st_sof[c] = 0; st_lanes[c] = '0; e_sof[c] = 0; e_lanes[c] = '0;
      e_cv[c] = 0; e_op[c] = '0; e_addr[c] = '0; e_err[c] = 0;
      ltag[c] = "R9"; ctag[c] = "R6";
    end
    // addressed and foreign slots mixed
    sched(2, frame(6'h2A, slot(1, 5, 1, 27'h0123456), slot(1, 3, 2, 27'h7FFFFFF),
                   slot(1, 5, 3, 27'h5A5A5A5), 0), "R2");
    // back to back, includes refresh and a no-op
    sched(14, frame(6'h15, slot(1, 5, 2, 27'h0000001), slot(1, 5, 4, 27'h4000000),
                    slot(1, 5, 0, 27'h1111111), 0), "R10");
    // bad CRC, still forwarded, no commands
    sched(26, frame(6'h3F, slot(1, 5, 2, 27'h2222222), slot(1, 5, 2, 27'h3333333),
                    slot(1, 5, 2, 27'h4444444), 1), "R3");
    // reserved opcode, invalid slot, then a write
    sched(40, frame(6'h01, slot(1, 5, 6, 27'h6666666), slot(0, 5, 2, 27'h7777777),
                    slot(1, 5, 3, 27'h0ABCDEF), 0), "R2");
    // partial frame cut off by an early start
    for (int k = 0; k < 5; k++) begin
      st_sof[60+k] = (k == 0);
      st_lanes[60+k] = 10'h3C3 ^ 10'(k);
    end
    for (int c = 72; c < 77; c++) ltag[c] = "R8";
    sched(65, frame(6'h0C, slot(1, 2, 1, 27'h1234567), slot(1, 5, 1, 27'h0FEDCBA),
                    slot(1, 7, 3, 27'h0000042), 0), "R8");
    // stray lane noise with no frame start
    for (int c = 90; c < 100; c++) st_lanes[c] = 10'h2B5 ^ 10'(c);
    // no slot for this module
    sched(100, frame(6'h33, slot(1, 0, 1, 27'h1), slot(1, 4, 2, 27'h2),
                     slot(1, 6, 3, 27'h3), 0), "R3");
    sched(112, frame(6'h05, slot(1, 5, 4, 27'h7000001), slot(1, 5, 3, 27'h0000003),
                     slot(1, 5, 1, 27'h5555555), 0), "R10");

    repeat (3) @(posedge clk);
    #2;
    check("R1", {out_sof, crc_err, cmd_valid}, 3'b000, -1);
    check("R1", {22'd0, out_lanes}, 32'd0, -1);
    check("R1", {2'd0, cmd_op, cmd_addr}, 32'd0, -1);
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      @(posedge clk);
      #1;
      in_sof = st_sof[c];
      in_lanes = st_lanes[c];
      #2;
      check(c < 14 ? "R1" : "R2", {31'd0, out_sof}, {31'd0, e_sof[c]}, c);
      check(ltag[c], {22'd0, out_lanes}, {22'd0, e_lanes[c]}, c);
      check(ctag[c], {31'd0, cmd_valid}, {31'd0, e_cv[c]}, c);
      check(ctag[c], {2'd0, cmd_op, cmd_addr}, {2'd0, e_op[c], e_addr[c]}, c);
      check("R4", {31'd0, crc_err}, {31'd0, e_err[c]}, c);
    end
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule